// File: doc/BRIEF.md
# Floating-Point Status Register with Compare Queue

This block keeps the 32-bit status word of a floating-point unit. Three events change it. A whole-word load replaces it. A finished arithmetic operation reports five exception flags, which accumulate in sticky bits. A finished compare first merges its flags in the same way, then records a condition outcome. The arithmetic and compare datapaths sit outside the block and deliver their results on its inputs: the flags, a relation code, a condition mask and a target index.

The word supplies two controls to the arithmetic units: the rounding mode and the flush-to-zero enable. When a reported flag meets its enable bit, the block raises a trap request one cycle later. A compare stores its outcome in one of two ways. A nonzero target index writes a single bit of a condition array. A zero index pushes the outcome into a shifting queue, and the previous primary condition bit moves down to the head of that queue.

Top module: `fpstat_reg`

## Requirements
- R1: `ld_valid` replaces the whole register with `ld_data` on the next clock edge. A load has priority over an operation or compare in the same cycle.
- R2: `round_mode` equals register bits 10:9: 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: `flush_en` equals register bit 5.
- R4: An operation that reports all-zero flags leaves the register unchanged. A cycle with no valid input also leaves it unchanged.
- R5: Reported flags are ORed into sticky bits and never clear a bit that is already set. The mapping is flags[0] inexact to bit 27, flags[1] underflow to 28, flags[2] overflow to 29, flags[3] divide-by-zero to 30, flags[4] invalid to 31.
- R6: `trap_req` is high in the cycle after an operation or compare in which (flags & register[4:0]) is nonzero. Enable bit i pairs with flags[i]. A load cycle never raises a trap.
- R7: The compare outcome comes from the condition mask. The relation code selects the bit: 0 = less takes mask[3], 1 = equal takes mask[2], 2 = greater takes mask[4], 3 = unordered takes mask[1].
- R8: A compare with target index y from 1 to 11 writes only bit 22-y with the outcome. An index of 12 to 15 changes no condition bit.
- R9: A compare with index 0 works as a queue. Bits 20:11 take the old bits 21:12, bit 21 takes the old bit 26, and bit 26 takes the outcome.
- R10: A compare applies its flag update first and its condition update after it, both in the same cycle.
- R11: `sig_cmp` equals cmp_mask[0] while `cmp_valid` is high, and is 0 otherwise.
- R12: After reset the register is zero and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Whole-register load strobe |
| ld_data | input | 32 | Value to load |
| op_valid | input | 1 | Arithmetic operation completed |
| cmp_valid | input | 1 | Compare completed |
| flags | input | 5 | Exception flags of the completed op or compare |
| cmp_rel | input | 2 | Compare relation code |
| cmp_mask | input | 5 | Compare condition mask |
| cmp_tgt | input | 4 | Compare target index, 0 = queued |
| status | output | 32 | Current register value |
| round_mode | output | 2 | Decoded rounding mode |
| flush_en | output | 1 | Flush-to-zero enable |
| trap_req | output | 1 | Enabled exception trap request |
| sig_cmp | output | 1 | Signaling compare select |

## Verification
The bench drives every combination of flags and enables, so a design that compares against the updated enables or uses the wrong bit order would raise traps in the wrong cases. It sweeps every relation, mask and target index on top of a nonzero background word. This catches an outcome bit taken from the wrong mask position, a target written one bit off, an index above 11 that clobbers bit 10 or lower, and a queue shift that loses bit 26 or fails to move bit 21. Loads issued together with operations or compares check load priority and confirm that a load cycle raises no trap.

// File: rtl/fpstat_reg.sv
module fpstat_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic [31:0] ld_data,
  input  logic        op_valid,
  input  logic        cmp_valid,
  input  logic [4:0]  flags,
  input  logic [1:0]  cmp_rel,
  input  logic [4:0]  cmp_mask,
  input  logic [3:0]  cmp_tgt,
  output logic [31:0] status,
  output logic [1:0]  round_mode,
  output logic        flush_en,
  output logic        trap_req,
  output logic        sig_cmp
);
  localparam int STICKY_LSB = 27;
  localparam int QHEAD      = 21;
  localparam int PRIMARY    = 26;
  localparam int NTARGET    = 11;

  logic [31:0] reg_q, flagged, nxt;
  logic        outcome, upd;

  assign upd = op_valid | cmp_valid;
  assign flagged = upd ? (reg_q | ({27'b0, flags} << STICKY_LSB)) : reg_q;

  always_comb begin
    unique case (cmp_rel)
      2'd0: outcome = cmp_mask[3];
      2'd1: outcome = cmp_mask[2];
      2'd2: outcome = cmp_mask[4];
      default: outcome = cmp_mask[1];
    endcase
  end

  always_comb begin
    nxt = flagged;
    if (cmp_valid) begin
      if (cmp_tgt == 4'd0) begin
        nxt[QHEAD-1:11] = flagged[QHEAD:12];
        nxt[QHEAD]      = flagged[PRIMARY];
        nxt[PRIMARY]    = outcome;
      end else if (int'(cmp_tgt) <= NTARGET) begin
        nxt[QHEAD + 1 - int'(cmp_tgt)] = outcome;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q    <= '0;
      trap_req <= 1'b0;
    end else begin
      reg_q    <= ld_valid ? ld_data : nxt;
      trap_req <= !ld_valid && upd && |(flags & reg_q[4:0]);
    end
  end

  assign status     = reg_q;
  assign round_mode = reg_q[10:9];
  assign flush_en   = reg_q[5];
  assign sig_cmp    = cmp_valid & cmp_mask[0];

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> status == $past(ld_data));
  a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && !cmp_valid && (!op_valid || flags == 5'd0)) |=> status == $past(status));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (status[31:27] & $past(status[31:27])) == $past(status[31:27]));
  a_r6_trap_src: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid || !(op_valid || cmp_valid)) |=> !trap_req);
  a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> status[10:0] == $past(status[10:0]));
  a_r9_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !ld_valid && cmp_tgt == 4'd0) |=> status[21] == $past(status[26]));
  a_r11_sig: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |-> !sig_cmp);
endmodule

// File: tb/fpstat_reg_tb.sv
module fpstat_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, op_valid = 0, cmp_valid = 0;
  logic [31:0] ld_data = '0;
  logic [4:0] flags = '0, cmp_mask = '0;
  logic [1:0] cmp_rel = '0;
  logic [3:0] cmp_tgt = '0;
  logic [31:0] status;
  logic [1:0] round_mode;
  logic flush_en, trap_req, sig_cmp;

  int checks = 0, errors = 0;
  logic [31:0] exp_s = '0;

  always #2.5 clk = ~clk;

  fpstat_reg u_dut (.clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .op_valid(op_valid), .cmp_valid(cmp_valid), .flags(flags), .cmp_rel(cmp_rel),
    .cmp_mask(cmp_mask), .cmp_tgt(cmp_tgt), .status(status), .round_mode(round_mode),
    .flush_en(flush_en), .trap_req(trap_req), .sig_cmp(sig_cmp));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] s, input bit ld, input logic [31:0] d,
      input bit op, input bit cmp, input logic [4:0] f, input logic [1:0] rel,
      input logic [4:0] m, input logic [3:0] y);
    logic [31:0] r, old;
    logic o;
    if (ld) return d;
    r = s;
    if (op || cmp) r = r | (32'(f) << 27);
    if (cmp) begin
      o = (rel == 0) ? m[3] : (rel == 1) ? m[2] : (rel == 2) ? m[4] : m[1];
      if (y == 0) begin
        old = r;
        for (int i = 11; i <= 20; i++) r[i] = old[i+1];
        r[21] = old[26];
        r[26] = o;
      end else if (y <= 11) r[22 - y] = o;
    end
    return r;
  endfunction

  task automatic cyc(input bit ld, input logic [31:0] d, input bit op, input bit cmp,
      input logic [4:0] f, input logic [1:0] rel, input logic [4:0] m, input logic [3:0] y,
      input string req);
    logic et;
    @(negedge clk);
    ld_valid = ld; ld_data = d; op_valid = op; cmp_valid = cmp;
    flags = f; cmp_rel = rel; cmp_mask = m; cmp_tgt = y;
    #1;
    chk(sig_cmp == (cmp & m[0]), "R11", 32'(sig_cmp), 32'(cmp & m[0]));
    et = !ld && (op || cmp) && |(f & exp_s[4:0]);
    exp_s = model(exp_s, ld, d, op, cmp, f, rel, m, y);
    @(negedge clk);
    ld_valid = 0; op_valid = 0; cmp_valid = 0;
    chk(status == exp_s, req, status, exp_s);
    chk(trap_req == et, "R6", 32'(trap_req), 32'(et));
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(status == 0, "R12", status, 0);
    chk(trap_req == 0, "R12", 32'(trap_req), 0);

    // R2 R3 decode
    for (int k = 0; k < 8; k++) begin
      cyc(1, 32'(k[1:0]) << 9 | 32'(k[2]) << 5, 0, 0, 0, 0, 0, 0, "R1");
      chk(round_mode == k[1:0], "R2", 32'(round_mode), 32'(k[1:0]));
      chk(flush_en == k[2], "R3", 32'(flush_en), 32'(k[2]));
    end

    // R4 R5 R6: every enable set against every flag vector
    for (int en = 0; en < 32; en++) begin
      cyc(1, 32'(en), 0, 0, 0, 0, 0, 0, "R1");
      cyc(0, 0, 1, 0, 0, 0, 0, 0, "R4");
      for (int f = 0; f < 32; f++) cyc(0, 0, 1, 0, 5'(f), 0, 0, 0, "R5");
    end
    cyc(0, 0, 0, 0, 5'h1f, 0, 0, 0, "R4");

    // R1 priority over op/cmp
    cyc(1, 32'h0000_001f, 0, 0, 0, 0, 0, 0, "R1");
    cyc(1, 32'h1234_5600, 1, 1, 5'h1f, 2, 5'h1f, 0, "R1");

    // R7 R8 R9 R10: compares over all targets, relations, masks
    for (int y = 0; y < 16; y++) begin
      cyc(1, 32'h0A5A_5A03 ^ (32'(y) << 13), 0, 0, 0, 0, 0, 0, "R1");
      for (int rel = 0; rel < 4; rel++)
        for (int m = 0; m < 32; m++)
          cyc(0, 0, 0, 1, 5'((m + rel) & 3), 2'(rel), 5'(m), 4'(y),
              y == 0 ? "R9" : (y <= 11 ? "R8" : "R7"));
    end
    cyc(0, 0, 0, 1, 5'h10, 3, 5'h02, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule